// File: doc/BRIEF.md
# Region-Decoded Unified Data Memory

This block is a single word-addressed data store that a processor sees as one flat address space. One address port selects among three regions: a general-purpose RAM in the lower half, a frame-buffer RAM in the third quarter, and one read-only word that mirrors the code of the key currently pressed. Above that key word, every address is invalid. Reads are combinational. The output shows the selected word in the same cycle the address is applied. A write takes effect on the rising clock edge while the write strobe is high, and only a RAM or frame-buffer address stores data.

The address width `ADDR_W` sets the size of each region. The general RAM holds 2^(ADDR_W-1) words and the frame buffer holds 2^(ADDR_W-2) words. The key word sits at address 3·2^(ADDR_W-2). With `ADDR_W` = 15 the map is as follows: RAM at 0–16383, frame buffer at 16384–24575 with a 13-bit local address, key word at 24576, and invalid space above that. The default configuration is a reduced one with `ADDR_W` = 9: RAM at 0–255, frame buffer at 256–383, key word at 384, and invalid space at 385–511.

The frame buffer is plain storage. Pixel generation is outside this block, and so is keyboard scanning: the key code arrives on an input port.

Top module: `mm_data_memory`

## Requirements
- R1: During the cycles after a synchronous active-high reset, and before any write, every RAM and frame-buffer address reads zero.
- R2: An address whose top bit is 0 selects the general RAM. The local word index is the address itself. A word written there reads back unchanged.
- R3: An address whose two top bits are 10 selects the frame buffer. The local index is the low ADDR_W-2 address bits. Data written there reads back unchanged.
- R4: The address 3·2^(ADDR_W-2) reads the `key_code` input. The output follows `key_code` combinationally, with no clock edge needed.
- R5: Every address above the key address reads zero.
- R6: A write to the key address or to an invalid address has no effect. Afterwards, every RAM and frame-buffer word still holds its earlier value.
- R7: A write is committed on the rising clock edge. While the strobe is high before that edge, a read of the same address returns the old value. Just after the edge, it returns the new value.
- R8: A write to one region never alters a word in the other region. The frame-buffer local index does not alias onto RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears RAM and frame buffer |
| wr_data | input | DATA_W | Word to store |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address for both read and write |
| key_code | input | DATA_W | Code of the key currently held |
| rd_data | output | DATA_W | Contents of the addressed word |

## Verification
The bench sweeps all 512 addresses of the reduced map three times:

1. **Just after reset.** This sweep separates the zero-initialised stores from the live key word.
2. **After a write to every address.** Each write uses an address-dependent pattern, so a wrong local index or a RAM-to-frame-buffer alias shows up as a mismatched word. This sweep also exercises the ignored writes to the key and invalid addresses.
3. **After a second pass that writes only the frame buffer.** This sweep shows that RAM is untouched.

Around each write, the bench samples before and after the edge to tell a committed write from a read-through. Changing `key_code` while the address is held at the key word shows whether the read is combinational.

// File: rtl/mm_data_memory_pkg.sv
package mm_data_memory_pkg;

    typedef enum logic [1:0] {
        RGN_RAM    = 2'd0,
        RGN_SCREEN = 2'd1,
        RGN_KEY    = 2'd2,
        RGN_NONE   = 2'd3
    } region_e;

    // Classify an address of width aw (passed zero-extended to 32 bits)
    function automatic region_e region_of(input logic [31:0] a, input int aw);
        logic [31:0] key_at;
        key_at = 32'd3 << (aw - 2);
        if (a[aw-1] == 1'b0)
            return RGN_RAM;
        else if (a[aw-2] == 1'b0)
            return RGN_SCREEN;
        else if (a == key_at)
            return RGN_KEY;
        else
            return RGN_NONE;
    endfunction

endpackage

// File: rtl/mm_region_decode.sv
module mm_region_decode
    import mm_data_memory_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output region_e           region,
    output logic              ram_we,
    output logic              scr_we
);

    always_comb begin
        region = region_of(32'(addr), ADDR_W);
        ram_we = wr_en && (region == RGN_RAM);
        scr_we = wr_en && (region == RGN_SCREEN);
    end

    // R8
    one_store_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_we, scr_we}));

    // R6
    no_write_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1] && addr[ADDR_W-2]) |-> !(ram_we || scr_we));

endmodule

// File: rtl/mm_word_bank.sv
module mm_word_bank #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

    assign rdata = cells[idx];

    // R7
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (we ##1 (idx == $past(idx))) |-> (rdata == $past(wdata)));

    // R6
    hold_without_we_chk: assert property (@(posedge clk) disable iff (rst)
        (!we ##1 (idx == $past(idx))) |-> (rdata == $past(rdata)));

endmodule

// File: rtl/mm_data_memory.sv
module mm_data_memory
    import mm_data_memory_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] key_code,
    output logic [DATA_W-1:0] rd_data
);

    localparam int RAM_IW = ADDR_W - 1;
    localparam int SCR_IW = ADDR_W - 2;

    region_e           region;
    logic              ram_we, scr_we;
    logic [DATA_W-1:0] ram_q, scr_q;

    mm_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .wr_en  (wr_en),
        .region (region),
        .ram_we (ram_we),
        .scr_we (scr_we)
    );

    mm_word_bank #(.IDX_W(RAM_IW), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .idx   (addr[RAM_IW-1:0]),
        .wdata (wr_data),
        .rdata (ram_q)
    );

    mm_word_bank #(.IDX_W(SCR_IW), .DATA_W(DATA_W)) u_scr (
        .clk   (clk),
        .rst   (rst),
        .we    (scr_we),
        .idx   (addr[SCR_IW-1:0]),
        .wdata (wr_data),
        .rdata (scr_q)
    );

    always_comb begin
        unique case (region)
            RGN_RAM:    rd_data = ram_q;
            RGN_SCREEN: rd_data = scr_q;
            RGN_KEY:    rd_data = key_code;
            default:    rd_data = '0;
        endcase
    end

    // R5
    invalid_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr > ADDR_W'(3 << SCR_IW)) |-> (rd_data == '0));

    // R4
    key_passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(3 << SCR_IW)) |-> (rd_data == key_code));

endmodule

// File: tb/mm_data_memory_test.sv
module mm_data_memory_test;

    localparam int AW = 9;
    localparam int DW = 16;
    localparam int NADDR = 1 << AW;
    localparam int RAM_N = 1 << (AW - 1);
    localparam int SCR_N = 1 << (AW - 2);
    localparam int KEY_A = RAM_N + SCR_N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] key_code = 16'hA5C3;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] m_ram [RAM_N];
    logic [DW-1:0] m_scr [SCR_N];

    always #2 clk = ~clk;

    mm_data_memory #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en),
        .addr(addr), .key_code(key_code), .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] expect_at(input int a);
        if (a < RAM_N) return m_ram[a];
        if (a < KEY_A) return m_scr[a - RAM_N];
        if (a == KEY_A) return key_code;
        return '0;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] exp);
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, rd_data, exp);
        end
    endtask

    function automatic string req_of(input int a);
        if (a < RAM_N) return "R2";
        if (a < KEY_A) return "R3";
        if (a == KEY_A) return "R4";
        return "R5";
    endfunction

    task automatic sweep(input string tag);
        for (int a = 0; a < NADDR; a++) begin
            @(negedge clk);
            addr = AW'(a);
            #1 check({tag, "/", req_of(a)}, expect_at(a));
        end
    endtask

    task automatic write_word(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = AW'(a);
        wr_data = d;
        wr_en = 1'b1;
        #1 check("R7 pre-edge", expect_at(a));
        @(posedge clk);
        if (a < RAM_N) m_ram[a] = d;
        else if (a < KEY_A) m_scr[a - RAM_N] = d;
        #1 wr_en = 1'b0;
        check("R7 post-edge", expect_at(a));
    endtask

    initial begin
        #150000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < RAM_N; i++) m_ram[i] = '0;
        for (int i = 0; i < SCR_N; i++) m_scr[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: all stores clear after reset
        sweep("R1");

        // R2 R3 R6 R7: write every address with an address-dependent pattern
        for (int a = 0; a < NADDR; a++)
            write_word(a, DW'((a * 16'h9E37) ^ 16'h5A5A));

        // R6 R8: read everything back
        sweep("R6");

        // R8: rewrite only the frame buffer; RAM must keep its contents
        for (int a = RAM_N; a < KEY_A; a++)
            write_word(a, DW'(~(a * 16'h3B1)));
        sweep("R8");

        // R4: the key word follows key_code without a clock edge
        @(negedge clk);
        addr = AW'(KEY_A);
        for (int k = 0; k < 6; k++) begin
            key_code = DW'(16'h1 << (k * 3)) ^ DW'(k);
            #1 check("R4 live", key_code);
        end

        // R8: address changes show new words without a clock edge
        addr = AW'(5);
        #1 check("R8 comb-ram", m_ram[5]);
        addr = AW'(RAM_N + 5);
        #1 check("R8 comb-scr", m_scr[5]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule